// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block handles operand bypass and interlock for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). An instruction in the execute stage may need a result that an older instruction has computed but has not yet written back. The block compares that instruction's two source register numbers with the destinations held in the execute/memory and memory/write-back pipeline registers. It then drives the two ALU operand multiplexer selects, so that each operand comes from the register value, the memory-stage result or the write-back-stage result.

A dependency can be too close for any bypass to cover. This happens when a load in the execute stage feeds the instruction being decoded. It also happens for every read-after-write dependency when forwarding is turned off at elaboration. In those cases the block raises one stall request. That request freezes the program counter and the fetch/decode register and puts a bubble into the decode/execute register. The block also holds the architectural register file. A write at a clock edge is already visible to reads in the same cycle, which models a file that writes in the first half-cycle and reads in the second. The third instruction after a producer therefore needs no bypass.

Top module: `fwd_unit`

## Requirements
- R1: With forwarding on, an execute-stage source that equals the memory-stage destination (write enable high, register nonzero) sets its operand select to 2'b01.
- R2: With forwarding on, an execute-stage source that matches only the write-back-stage destination (write enable high, register nonzero) sets its select to 2'b10.
- R3: When both the memory-stage and the write-back-stage destinations match a source, the select is 2'b01, so the younger result wins.
- R4: Register 0 never matches, and a stage whose write enable is low never matches. Such inputs leave the select at 2'b00 and never cause a stall.
- R5: A register write with the write enable high and a nonzero destination is returned by a decode read of that register in the same cycle, and it is still held after the clock edge. A read of register 0 returns zero, and a write to register 0 has no effect.
- R6: With forwarding on, stall is high exactly when a decode-stage source (nonzero) equals the destination of an execute-stage load whose write enable is high. A non-load producer in the execute stage causes no stall.
- R7: With forwarding off, both selects stay 2'b00. Stall is high while a decode source matches the execute-stage or memory-stage destination. The consumer therefore waits in decode for three cycles and reads the new value in the producer's write-back cycle.
- R8: Instructions with no dependency on the two stages ahead of them are never stalled and use select 2'b00.
- R9: After reset the selects are 2'b00, stall is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the register file |
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| ex_rs1 | input | AW | Execute-stage first source register |
| ex_rs2 | input | AW | Execute-stage second source register |
| ex_rd | input | AW | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ma_rd | input | AW | Memory-stage destination register |
| ma_we | input | 1 | Memory-stage write enable |
| wb_rd | input | AW | Write-back destination register |
| wb_we | input | 1 | Write-back write enable |
| wb_data | input | XLEN | Write-back result |
| opa_sel | output | 2 | ALU operand A source: 00 register, 01 memory stage, 10 write-back stage |
| opb_sel | output | 2 | ALU operand B source, same encoding |
| stall | output | 1 | Hold PC and fetch/decode, bubble into decode/execute |
| id_opa | output | XLEN | Register file value of id_rs1 |
| id_opb | output | XLEN | Register file value of id_rs2 |

## Verification
Selecting the bypass for the execute-stage instruction and interlocking the decode-stage instruction are independent decisions, and both can happen in the same cycle. A vector drives a memory-stage destination that matches an execute source while an execute-stage load also matches a decode source. The bench expects select 2'b01 together with stall high. A second case drives a register file write and a decode read of the same register in one cycle. It expects the written value on the read port in that cycle, while the stall-only instance drops its interlock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_RF = 2'b00,
    SRC_MA = 2'b01,
    SRC_WB = 2'b10
  } opsrc_e;

  // Younger stage wins when both stages hold the wanted register
  function automatic opsrc_e pick_src(input logic ma_hit, input logic wb_hit);
    if (ma_hit)      return SRC_MA;
    else if (wb_hit) return SRC_WB;
    else             return SRC_RF;
  endfunction

endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rs,
  input  logic [AW-1:0] ma_rd,
  input  logic          ma_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output opsrc_e        sel
);

  function automatic logic dest_hit(input logic [AW-1:0] src,
                                    input logic [AW-1:0] dst,
                                    input logic          we);
    return we && (dst == src) && (src != '0);
  endfunction

  logic hit_ma;
  logic hit_wb;

  assign hit_ma = dest_hit(rs, ma_rd, ma_we);
  assign hit_wb = dest_hit(rs, wb_rd, wb_we);

  always_comb begin
    if (FWD_EN) sel = pick_src(hit_ma, hit_wb);
    else        sel = SRC_RF;
  end

  a_r3_younger_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_WB) |-> !(ma_we && ma_rd == rs));

  a_r4_reg0_unbypassed: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0) |-> (sel == SRC_RF));

  a_r1_ma_sel_has_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_MA) |-> (ma_we && rs != '0));

endmodule

// File: rtl/hazard_detect.sv
module hazard_detect #(
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] ma_rd,
  input  logic          ma_we,
  output logic          stall
);

  function automatic logic reads_dest(input logic [AW-1:0] s1,
                                      input logic [AW-1:0] s2,
                                      input logic [AW-1:0] dst,
                                      input logic          we);
    return we && (dst != '0) && ((s1 == dst) || (s2 == dst));
  endfunction

  logic dep_ex;
  logic dep_ma;
  logic load_use;

  assign dep_ex   = reads_dest(id_rs1, id_rs2, ex_rd, ex_we);
  assign dep_ma   = reads_dest(id_rs1, id_rs2, ma_rd, ma_we);
  assign load_use = dep_ex && ex_load;

  // Forwarding covers everything except a load one slot ahead;
  // without it, the split-cycle file covers only the write-back slot
  always_comb begin
    if (FWD_EN) stall = load_use;
    else        stall = dep_ex || dep_ma;
  end

  a_r4_no_stall_on_r0: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (id_rs1 != '0 || id_rs2 != '0));

  a_r6_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (FWD_EN && stall) |-> (ex_load && ex_we));

  a_r7_stall_needs_writer: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_we || ma_we));

endmodule

// File: rtl/split_rf.sv
module split_rf #(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr [2],
  output logic [XLEN-1:0] rd_data [2]
);

  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] mem [NREG];
  logic            wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Write in the first half-cycle, read in the second: a read of the
  // register being written sees the incoming value
  function automatic logic [XLEN-1:0] read_port(input logic [AW-1:0] a,
                                                input logic [XLEN-1:0] stored);
    if (a == '0)                        return '0;
    else if (wr_live && wr_addr == a)   return wr_data;
    else                                return stored;
  endfunction

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = read_port(rd_addr[p], mem[rd_addr[p]]);

    a_r5_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] == '0) |-> (rd_data[p] == '0));

    a_r5_write_persists: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 &&
       rd_addr[p] == $past(wr_addr) && !(wr_en && wr_addr == rd_addr[p]))
      |-> (rd_data[p] == $past(wr_data)));
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW     = 5,
  parameter int XLEN   = 32,
  parameter bit FWD_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_rs1,
  input  logic [AW-1:0]   id_rs2,
  input  logic [AW-1:0]   ex_rs1,
  input  logic [AW-1:0]   ex_rs2,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_we,
  input  logic            ex_load,
  input  logic [AW-1:0]   ma_rd,
  input  logic            ma_we,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_we,
  input  logic [XLEN-1:0] wb_data,
  output logic [1:0]      opa_sel,
  output logic [1:0]      opb_sel,
  output logic            stall,
  output logic [XLEN-1:0] id_opa,
  output logic [XLEN-1:0] id_opb
);

  logic [AW-1:0]   ex_src [2];
  logic [AW-1:0]   id_src [2];
  logic [XLEN-1:0] id_val [2];
  opsrc_e          op_sel [2];

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fwd_select #(.AW(AW), .FWD_EN(FWD_EN)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .rs    (ex_src[k]),
      .ma_rd (ma_rd),
      .ma_we (ma_we),
      .wb_rd (wb_rd),
      .wb_we (wb_we),
      .sel   (op_sel[k])
    );
  end

  assign opa_sel = op_sel[0];
  assign opb_sel = op_sel[1];

  hazard_detect #(.AW(AW), .FWD_EN(FWD_EN)) u_haz (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_rs1  (id_rs1),
    .id_rs2  (id_rs2),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_load (ex_load),
    .ma_rd   (ma_rd),
    .ma_we   (ma_we),
    .stall   (stall)
  );

  split_rf #(.AW(AW), .XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wb_we),
    .wr_addr (wb_rd),
    .wr_data (wb_data),
    .rd_addr (id_src),
    .rd_data (id_val)
  );

  assign id_opa = id_val[0];
  assign id_opb = id_val[1];

  a_r7_off_means_rf: assert property (@(posedge clk) disable iff (!rst_n)
    !FWD_EN |-> (opa_sel == 2'b00 && opb_sel == 2'b00));

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

  localparam int AW   = 5;
  localparam int XLEN = 32;

  typedef struct packed {
    logic [4:0] xs1, xs2, mrd;
    logic       mwe;
    logic [4:0] wrd;
    logic       wwe;
    logic [4:0] is1, is2, xrd;
    logic       xwe, xld;
    logic [1:0] ea, eb;
    logic       sf, sn;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R8 nothing shared
    '{5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 5'd6, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'd8},
    // R1 operand A from memory stage
    '{5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd8, 5'd9, 5'd7, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 4'd1},
    // R2 operand B from write-back stage
    '{5'd1, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 5'd8, 5'd9, 5'd7, 1'b1, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 4'd2},
    // R3 both stages hold r5
    '{5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 5'd8, 5'd9, 5'd7, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 4'd3},
    // R4 register zero everywhere
    '{5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 4'd4},
    // R4 write enables low
    '{5'd6, 5'd7, 5'd6, 1'b0, 5'd7, 1'b0, 5'd10, 5'd11, 5'd10, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 4'd4},
    // R6 load feeding decode
    '{5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd9, 5'd11, 5'd11, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 1'b1, 4'd6},
    // R6 ALU producer in execute: no stall when forwarding
    '{5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd12, 5'd9, 5'd12, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd6},
    // R7 memory-stage producer
    '{5'd1, 5'd2, 5'd13, 1'b1, 5'd4, 1'b1, 5'd13, 5'd9, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd7},
    // R7 write-back producer: covered by the register file
    '{5'd1, 5'd2, 5'd3, 1'b1, 5'd14, 1'b1, 5'd8, 5'd14, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'd7},
    // R1 and R6 together: bypass and load interlock in one cycle
    '{5'd15, 5'd2, 5'd15, 1'b1, 5'd4, 1'b1, 5'd16, 5'd9, 5'd16, 1'b1, 1'b1, 2'b01, 2'b00, 1'b1, 1'b1, 4'd1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0]   ex_rd = '0, ma_rd = '0, wb_rd = '0;
  logic            ex_we = 1'b0, ex_load = 1'b0, ma_we = 1'b0, wb_we = 1'b0;
  logic [XLEN-1:0] wb_data = '0;

  logic [1:0]      f_sa, f_sb, n_sa, n_sb;
  logic            f_st, n_st;
  logic [XLEN-1:0] f_oa, f_ob, n_oa, n_ob;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fwd_unit #(.AW(AW), .XLEN(XLEN), .FWD_EN(1'b1)) u_fwd_unit (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
    .ex_load(ex_load), .ma_rd(ma_rd), .ma_we(ma_we), .wb_rd(wb_rd),
    .wb_we(wb_we), .wb_data(wb_data), .opa_sel(f_sa), .opb_sel(f_sb),
    .stall(f_st), .id_opa(f_oa), .id_opb(f_ob)
  );

  fwd_unit #(.AW(AW), .XLEN(XLEN), .FWD_EN(1'b0)) u_fwd_unit_nofwd (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
    .ex_load(ex_load), .ma_rd(ma_rd), .ma_we(ma_we), .wb_rd(wb_rd),
    .wb_we(wb_we), .wb_data(wb_data), .opa_sel(n_sa), .opb_sel(n_sb),
    .stall(n_st), .id_opa(n_oa), .id_opb(n_ob)
  );

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0;
    ex_rd = '0; ma_rd = '0; wb_rd = '0;
    ex_we = 0; ex_load = 0; ma_we = 0; wb_we = 0; wb_data = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9 reset state
    chk("R9", "opa_sel", {30'd0, f_sa}, 32'd0);
    chk("R9", "opb_sel", {30'd0, f_sb}, 32'd0);
    chk("R9", "stall", {31'd0, f_st}, 32'd0);
    id_rs1 = 5'd9; id_rs2 = 5'd31;
    #1;
    chk("R9", "r9 after reset", f_oa, 32'd0);
    chk("R9", "r31 after reset", f_ob, 32'd0);

    // table walk, register file data kept zero
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v = VECS[i];
      rq = $sformatf("R%0d", v.tag);
      @(negedge clk);
      ex_rs1 = v.xs1; ex_rs2 = v.xs2; ma_rd = v.mrd; ma_we = v.mwe;
      wb_rd = v.wrd; wb_we = v.wwe; wb_data = '0;
      id_rs1 = v.is1; id_rs2 = v.is2; ex_rd = v.xrd; ex_we = v.xwe; ex_load = v.xld;
      #2;
      chk(rq, "opa_sel", {30'd0, f_sa}, {30'd0, v.ea});
      chk(rq, "opb_sel", {30'd0, f_sb}, {30'd0, v.eb});
      chk(rq, "stall fwd", {31'd0, f_st}, {31'd0, v.sf});
      chk(rq, "stall nofwd", {31'd0, n_st}, {31'd0, v.sn});
      chk("R7", "nofwd selects", {30'd0, n_sa | n_sb}, 32'd0);
    end

    // R5 same-cycle write then read
    @(negedge clk);
    clear_in();
    wb_we = 1; wb_rd = 5'd9; wb_data = 32'hA5A5_0009; id_rs1 = 5'd9;
    #2;
    chk("R5", "read during write", f_oa, 32'hA5A5_0009);
    settle();
    wb_we = 0; wb_data = 32'hDEAD_BEEF;
    #1;
    chk("R5", "held after edge", f_oa, 32'hA5A5_0009);
    // R5 write to register zero dropped
    wb_we = 1; wb_rd = 5'd0; wb_data = 32'hFFFF_FFFF; id_rs2 = 5'd0;
    #1;
    chk("R5", "r0 during write", f_ob, 32'd0);
    settle();
    wb_we = 0;
    #1;
    chk("R5", "r0 after write", f_ob, 32'd0);

    // R7 stall-only: producer r17 walks execute, memory, write-back
    clear_in();
    id_rs1 = 5'd17; ex_rd = 5'd17; ex_we = 1;
    #1;
    chk("R7", "stall producer in execute", {31'd0, n_st}, 32'd1);
    chk("R6", "no fwd stall for ALU producer", {31'd0, f_st}, 32'd0);
    settle();
    ex_rd = '0; ex_we = 0; ma_rd = 5'd17; ma_we = 1;
    #1;
    chk("R7", "stall producer in memory", {31'd0, n_st}, 32'd1);
    settle();
    ma_rd = '0; ma_we = 0; wb_rd = 5'd17; wb_we = 1; wb_data = 32'h0000_1234;
    #1;
    chk("R7", "release at write-back", {31'd0, n_st}, 32'd0);
    chk("R7", "value read at write-back", n_oa, 32'h0000_1234);

    // R6 load r18 then consumer: one stall, then write-back bypass
    settle();
    clear_in();
    id_rs2 = 5'd18; ex_rd = 5'd18; ex_we = 1; ex_load = 1;
    #1;
    chk("R6", "load-use stall", {31'd0, f_st}, 32'd1);
    settle();
    ex_rd = '0; ex_we = 0; ex_load = 0; ma_rd = 5'd18; ma_we = 1;
    #1;
    chk("R6", "single bubble", {31'd0, f_st}, 32'd0);
    settle();
    id_rs2 = '0; ma_rd = '0; ma_we = 0;
    ex_rs2 = 5'd18; wb_rd = 5'd18; wb_we = 1; wb_data = 32'h55;
    #1;
    chk("R2", "load value from write-back", {30'd0, f_sb}, 32'd2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule